// File: doc/BRIEF.md
# 1-Wire slave bit-slot transceiver

This block is the timing layer of a 1-Wire slave. It runs on a system clock with a one-cycle microsecond tick enable, and it watches a synchronised copy of the shared open-drain data line. It recognises reset pulses and answers each one with a delayed presence pulse. It turns master write slots into received bits and answers master read slots by holding the line low for a 0. The block never drives the line high. Its only line-side output is a pull-down enable, which the pad turns into an open-drain driver, so the bus resolves as a wired AND.

Upward, the block gives a one-cycle reset strobe, a received-bit strobe with its value, and a one-cycle request each time the bit offered for a read slot has been taken. The layer above decides slot by slot whether the slave transmits, by raising `tx_en` and placing the outgoing bit on `tx_bit` before the slot's falling edge. Every duration is a parameter counted in microsecond ticks. The default values are a 480 µs reset threshold, a 30 µs presence delay, a 120 µs presence pulse, a 30 µs write sample point and a 45 µs hold for a transmitted 0.

Top module: `ow_slot_xcvr`

## Requirements
- R1: When the synchronised line has been low for RESET_US ticks, `rst_pulse` is high for exactly one cycle and `pull_low` is low from the next cycle. A low period shorter than RESET_US ticks produces no strobe.
- R2: After the line rises at the end of a reset, the block waits PRES_WAIT_US ticks. It then holds `pull_low` high for exactly PRES_LEN_US ticks.
- R3: When a slot starts with `tx_en` low, the block samples the line PRES-independent at SAMPLE_US ticks after the falling edge. It pulses `rx_valid` once and sets `rx_bit` to 1 for a high line or 0 for a low line.
- R4: When a slot starts with `tx_en` high and `tx_bit` at 0, `pull_low` rises in the cycle after the edge is detected and stays high for exactly TX_HOLD_US ticks. When `tx_bit` is 1, `pull_low` stays low for the whole slot.
- R5: A read slot produces exactly one `tx_req` pulse, in the same cycle that the pull-down decision takes effect, and it produces no `rx_valid`.
- R6: The block's own release of the line, at the end of a presence pulse or of a transmitted 0, starts no slot. No `rx_valid` or `tx_req` follows it.
- R7: A falling edge while the block waits before or drives a presence pulse starts no slot, and the presence pulse still comes on time.
- R8: A reset length low overrides any activity in progress, including a read slot that is pulling the line low. It yields one `rst_pulse` and then a normal presence pulse.
- R9: After `rst_n`, all outputs are low, and an idle high line produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| line_in | input | 1 | Raw level of the shared data line |
| tx_en | input | 1 | Next slot is a read slot that the slave answers |
| tx_bit | input | 1 | Bit to send in that read slot |
| pull_low | output | 1 | Pull-down enable for the open-drain pad |
| rst_pulse | output | 1 | One-cycle strobe on reset detection |
| rx_valid | output | 1 | One-cycle strobe when a written bit is sampled |
| rx_bit | output | 1 | Last sampled write-slot bit |
| tx_req | output | 1 | One-cycle strobe when the read-slot bit is taken |

## Verification
Two events can fall on the same clock edge: the detection of a slot's falling edge and a microsecond tick. When they coincide, the slot timer must restart from zero and ignore that tick. Random idle gaps, counted in clocks, move each falling edge across the four-cycle tick phase. Each such case is judged by whether the write sample lands between SAMPLE_US and SAMPLE_US+1 bench-counted ticks and whether a transmitted 0 lasts exactly TX_HOLD_US ticks. A second collision is a reset threshold that arrives while a read-0 slot is still in progress. A directed long low during such a slot must give one reset strobe, a released line and a fresh presence pulse.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

   // Slot engine states
   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_RST_LOW    = 3'd1,
      ST_PRES_WAIT  = 3'd2,
      ST_PRES_DRIVE = 3'd3,
      ST_SLOT_RX    = 3'd4,
      ST_SLOT_TX    = 3'd5,
      ST_SLOT_END   = 3'd6
   } ow_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_s,
   output logic fall,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= line_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain[STAGES-1];
   end

   assign line_s = chain[STAGES-1];
   assign fall   = prev_q & ~line_s;
   assign rise   = ~prev_q & line_s;

endmodule

// File: rtl/ow_tick_timer.sv
module ow_tick_timer #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [WIDTH-1:0] cnt
);

   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   // Saturating tick counter, synchronous clear has priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (clr)                       cnt <= '0;
      else if (tick && (cnt != CNT_MAX))  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
   import ow_slot_pkg::*;
#(
   parameter int unsigned RESET_US     = 480,
   parameter int unsigned PRES_WAIT_US = 30,
   parameter int unsigned PRES_LEN_US  = 120,
   parameter int unsigned SAMPLE_US    = 30,
   parameter int unsigned TX_HOLD_US   = 45,
   parameter int unsigned TW           = 7,
   parameter int unsigned LW           = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line_s,
   input  logic          fall,
   input  logic          rise,
   input  logic [TW-1:0] t_cnt,
   input  logic [LW-1:0] low_cnt,
   input  logic          tx_en,
   input  logic          tx_bit,
   output logic          t_clr,
   output logic          pull_low,
   output logic          rst_pulse,
   output logic          rx_valid,
   output logic          rx_bit,
   output logic          tx_req
);

   localparam logic [TW-1:0] T_PWAIT  = TW'(PRES_WAIT_US - 1);
   localparam logic [TW-1:0] T_PLEN   = TW'(PRES_LEN_US - 1);
   localparam logic [TW-1:0] T_SAMPLE = TW'(SAMPLE_US - 1);
   localparam logic [TW-1:0] T_HOLD   = TW'(TX_HOLD_US - 1);
   localparam logic [LW-1:0] L_RESET  = LW'(RESET_US - 1);

   ow_state_e state_q, state_d;
   logic      drv_d, rst_d, rxv_d, rxb_d, req_d;
   logic      rst_hit;

   // Low-time threshold reached on this tick (counter saturates beyond it)
   assign rst_hit = tick && !line_s && (low_cnt == L_RESET);

   always_comb begin
      state_d = state_q;
      drv_d   = pull_low;
      rst_d   = 1'b0;
      rxv_d   = 1'b0;
      rxb_d   = rx_bit;
      req_d   = 1'b0;
      t_clr   = 1'b0;
      if (rst_hit) begin
         state_d = ST_RST_LOW;
         drv_d   = 1'b0;
         rst_d   = 1'b1;
         t_clr   = 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (fall) begin
                  t_clr = 1'b1;
                  if (tx_en) begin
                     state_d = ST_SLOT_TX;
                     drv_d   = ~tx_bit;
                     req_d   = 1'b1;
                  end else begin
                     state_d = ST_SLOT_RX;
                  end
               end
            end
            ST_RST_LOW: begin
               if (rise) begin
                  state_d = ST_PRES_WAIT;
                  t_clr   = 1'b1;
               end
            end
            ST_PRES_WAIT: begin
               if (tick && (t_cnt == T_PWAIT)) begin
                  state_d = ST_PRES_DRIVE;
                  drv_d   = 1'b1;
                  t_clr   = 1'b1;
               end
            end
            ST_PRES_DRIVE: begin
               if (tick && (t_cnt == T_PLEN)) begin
                  state_d = ST_IDLE;
                  drv_d   = 1'b0;
               end
            end
            ST_SLOT_RX: begin
               if (tick && (t_cnt == T_SAMPLE)) begin
                  state_d = ST_SLOT_END;
                  rxv_d   = 1'b1;
                  rxb_d   = line_s;
               end
            end
            ST_SLOT_TX: begin
               if (tick && (t_cnt == T_HOLD)) begin
                  state_d = ST_SLOT_END;
                  drv_d   = 1'b0;
               end
            end
            ST_SLOT_END: begin
               if (line_s) state_d = ST_IDLE;
            end
            default: begin
               state_d = ST_IDLE;
               drv_d   = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pull_low  <= 1'b0;
         rst_pulse <= 1'b0;
         rx_valid  <= 1'b0;
         rx_bit    <= 1'b0;
         tx_req    <= 1'b0;
      end else begin
         state_q   <= state_d;
         pull_low  <= drv_d;
         rst_pulse <= rst_d;
         rx_valid  <= rxv_d;
         rx_bit    <= rxb_d;
         tx_req    <= req_d;
      end
   end

endmodule

// File: rtl/ow_slot_xcvr.sv
module ow_slot_xcvr
   import ow_slot_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RESET_US     = 480,
   parameter int unsigned PRES_WAIT_US = 30,
   parameter int unsigned PRES_LEN_US  = 120,
   parameter int unsigned SAMPLE_US    = 30,
   parameter int unsigned TX_HOLD_US   = 45
) (
   input  logic clk,
   input  logic rst_n,
   input  logic us_tick,
   input  logic line_in,
   input  logic tx_en,
   input  logic tx_bit,
   output logic pull_low,
   output logic rst_pulse,
   output logic rx_valid,
   output logic rx_bit,
   output logic tx_req
);

   localparam int unsigned SLOT_MAX = max2(max2(PRES_WAIT_US, PRES_LEN_US),
                                           max2(SAMPLE_US, TX_HOLD_US));
   localparam int unsigned TW = $clog2(SLOT_MAX + 1);
   localparam int unsigned LW = $clog2(RESET_US + 1);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PRES_WAIT_US < 15 || PRES_WAIT_US > 60) begin : g_bad_pwait
      $error("PRES_WAIT_US must lie in 15..60");
   end
   if (PRES_LEN_US < 60 || PRES_LEN_US > 240) begin : g_bad_plen
      $error("PRES_LEN_US must lie in 60..240");
   end
   if (SAMPLE_US < 15 || SAMPLE_US > 60) begin : g_bad_sample
      $error("SAMPLE_US must lie in 15..60");
   end
   if (TX_HOLD_US < 15 || TX_HOLD_US >= 60) begin : g_bad_hold
      $error("TX_HOLD_US must lie in 15..59");
   end
   if (RESET_US <= PRES_LEN_US || RESET_US <= 60) begin : g_bad_reset
      $error("RESET_US must exceed the presence length and the slot length");
   end

   logic          line_s, fall, rise, t_clr;
   logic [TW-1:0] t_cnt;
   logic [LW-1:0] low_cnt;

   ow_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .line_in(line_in),
      .line_s(line_s), .fall(fall), .rise(rise)
   );

   ow_tick_timer #(.WIDTH(TW)) slot_tmr_i (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .tick(us_tick), .cnt(t_cnt)
   );

   ow_tick_timer #(.WIDTH(LW)) low_tmr_i (
      .clk(clk), .rst_n(rst_n), .clr(line_s), .tick(us_tick), .cnt(low_cnt)
   );

   ow_slot_fsm #(
      .RESET_US(RESET_US), .PRES_WAIT_US(PRES_WAIT_US), .PRES_LEN_US(PRES_LEN_US),
      .SAMPLE_US(SAMPLE_US), .TX_HOLD_US(TX_HOLD_US), .TW(TW), .LW(LW)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n), .tick(us_tick), .line_s(line_s),
      .fall(fall), .rise(rise), .t_cnt(t_cnt), .low_cnt(low_cnt),
      .tx_en(tx_en), .tx_bit(tx_bit), .t_clr(t_clr), .pull_low(pull_low),
      .rst_pulse(rst_pulse), .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req)
   );

endmodule

// File: rtl/ow_slot_xcvr_chk.sv
module ow_slot_xcvr_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_bit,
   input logic pull_low,
   input logic rst_pulse,
   input logic rx_valid,
   input logic tx_req
);

   // R1
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   // R8
   rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !pull_low);

   // R3
   rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R5
   req_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> !rx_valid);

   // R5
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);

   // R4
   tx_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (pull_low == !$past(tx_bit)));

endmodule

bind ow_slot_xcvr ow_slot_xcvr_chk chk_i (
   .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .pull_low(pull_low),
   .rst_pulse(rst_pulse), .rx_valid(rx_valid), .tx_req(tx_req)
);

// File: tb/ow_slot_xcvr_tb_top.sv
module ow_slot_xcvr_tb_top;

   localparam int RST_US = 480;
   localparam int PW     = 30;
   localparam int PL     = 120;
   localparam int SMP    = 30;
   localparam int HOLD   = 45;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, us_tick = 1'b0, m_low = 1'b0, tx_en = 1'b0, tx_bit = 1'b1;
   logic line_in, pull_low, rst_pulse, rx_valid, rx_bit, tx_req;

   // Wired AND of master and slave pull-downs
   assign line_in = ~(m_low | pull_low);

   ow_slot_xcvr #(
      .SYNC_STAGES(2), .RESET_US(RST_US), .PRES_WAIT_US(PW), .PRES_LEN_US(PL),
      .SAMPLE_US(SMP), .TX_HOLD_US(HOLD)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
      .tx_en(tx_en), .tx_bit(tx_bit), .pull_low(pull_low), .rst_pulse(rst_pulse),
      .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req)
   );

   int n_chk = 0, n_fail = 0;
   int us_count = 0, n_rst = 0, n_rx = 0, n_req = 0, n_plr = 0;
   int pl_start = 0, pl_end = 0, rx_us = 0;
   logic last_rx = 1'b0, pl_prev = 1'b0;

   // Monitor and tick source, both on the falling clock edge
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         if (us_tick) us_count++;
         if (rst_pulse) n_rst++;
         if (rx_valid) begin n_rx++; last_rx = rx_bit; rx_us = us_count; end
         if (tx_req) n_req++;
         if (pull_low && !pl_prev) begin n_plr++; pl_start = us_count; end
         if (!pull_low && pl_prev) pl_end = us_count;
         pl_prev = pull_low;
         ph = (ph + 1) % 4;
         us_tick = (ph == 0);
      end
   end

   function automatic bit in_win(input int v, input int lo, input int hi);
      return (v >= lo) && (v <= hi);
   endfunction

   function automatic logic exp_line(input logic b);
      return b;   // read slot: master sees the offered bit
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic wait_us(input int n);
      int k = 0;
      while (k < n) begin
         @(posedge clk);
         if (us_tick) k++;
      end
   endtask

   task automatic drive(input logic v, output int at);
      @(negedge clk);
      #1;
      m_low = v;
      at = us_count;
   endtask

   task automatic wr_slot(input logic b);
      int f, r, rx0, rq0;
      rx0 = n_rx; rq0 = n_req;
      drive(1'b1, f);
      wait_us(b ? 5 : 60);
      drive(1'b0, r);
      wait_us(b ? 70 : 15);
      chk(n_rx == rx0 + 1, "R3 one sample per write slot", n_rx - rx0, 1);
      chk(last_rx == b, "R3 sampled value", int'(last_rx), int'(b));
      chk(in_win(rx_us - f, SMP, SMP + 1), "R3 sample point", rx_us - f, SMP);
      chk(n_req == rq0, "R5 no request in write slot", n_req - rq0, 0);
   endtask

   task automatic rd_slot(input logic b);
      int f, r, rx0, rq0, p0;
      logic got;
      @(negedge clk);
      tx_en = 1'b1; tx_bit = b;
      rx0 = n_rx; rq0 = n_req; p0 = n_plr;
      drive(1'b1, f);
      wait_us(2);
      drive(1'b0, r);
      wait_us(10);
      @(negedge clk);
      got = line_in;
      wait_us(60);
      chk(got == exp_line(b), "R4 line level seen by master", int'(got), int'(b));
      chk(n_req == rq0 + 1, "R5 one request per read slot", n_req - rq0, 1);
      chk(n_rx == rx0, "R5 no sample in read slot", n_rx - rx0, 0);
      if (!b) begin
         chk(n_plr == p0 + 1, "R4 pull-down for a 0", n_plr - p0, 1);
         chk(pl_end - pl_start == HOLD, "R4 hold length", pl_end - pl_start, HOLD);
      end else begin
         chk(n_plr == p0, "R4 no pull-down for a 1", n_plr - p0, 0);
      end
      @(negedge clk);
      tx_en = 1'b0;
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int t, rel, rst0, rx0, rq0, p0;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(pull_low == 1'b0, "R9 pull_low after reset", int'(pull_low), 0);
      chk({rst_pulse, rx_valid, tx_req} == 3'b000, "R9 strobes after reset",
          int'({rst_pulse, rx_valid, tx_req}), 0);
      wait_us(100);
      chk(n_rst + n_rx + n_req + n_plr == 0, "R9 idle line quiet", n_rst + n_rx + n_req + n_plr, 0);

      // R1 / R2 reset and presence
      drive(1'b1, t);
      wait_us(RST_US + 10);
      chk(n_rst == 1, "R1 reset strobe", n_rst, 1);
      chk(pull_low == 1'b0, "R1 line released during reset", int'(pull_low), 0);
      drive(1'b0, rel);
      wait_us(PW + PL + 40);
      chk(in_win(pl_start - rel, PW, PW + 1), "R2 presence delay", pl_start - rel, PW);
      chk(pl_end - pl_start == PL, "R2 presence length", pl_end - pl_start, PL);
      // R6: the slot that began as a reset counts as one write-0; nothing after presence
      chk(n_rx == 1 && n_req == 0, "R6 no slot from own release", n_rx * 10 + n_req, 10);

      // R1 short low is not a reset
      rst0 = n_rst;
      drive(1'b1, t);
      wait_us(100);
      drive(1'b0, t);
      wait_us(20);
      chk(n_rst == rst0, "R1 short low no reset", n_rst - rst0, 0);

      wr_slot(1'b1);
      wr_slot(1'b0);
      rd_slot(1'b0);
      rd_slot(1'b1);

      // R7 falling edge during presence wait is ignored
      drive(1'b1, t);
      wait_us(RST_US + 10);
      drive(1'b0, rel);
      rx0 = n_rx; rq0 = n_req; p0 = n_plr;
      wait_us(10);
      drive(1'b1, t);
      wait_us(5);
      drive(1'b0, t);
      wait_us(PW + PL + 30);
      chk(n_rx == rx0 && n_req == rq0, "R7 no slot during presence wait",
          (n_rx - rx0) + (n_req - rq0), 0);
      chk(n_plr == p0 + 1, "R7 presence still produced", n_plr - p0, 1);
      chk(in_win(pl_start - rel, PW, PW + 1), "R7 presence delay kept", pl_start - rel, PW);

      // R8 reset overrides a read-0 slot
      @(negedge clk);
      tx_en = 1'b1; tx_bit = 1'b0;
      rst0 = n_rst; rx0 = n_rx; rq0 = n_req; p0 = n_plr;
      drive(1'b1, t);
      wait_us(RST_US + 10);
      chk(n_rst == rst0 + 1, "R8 reset during read slot", n_rst - rst0, 1);
      chk(pull_low == 1'b0, "R8 line released", int'(pull_low), 0);
      @(negedge clk);
      tx_en = 1'b0;
      drive(1'b0, rel);
      wait_us(PW + PL + 30);
      chk(n_plr == p0 + 2, "R8 drive then presence", n_plr - p0, 2);
      chk(n_req == rq0 + 1 && n_rx == rx0, "R8 one request no sample",
          (n_req - rq0) * 10 + (n_rx - rx0), 10);

      // Random mix; idle gaps shift edges against the tick phase
      for (int i = 0; i < 40; i++) begin
         repeat ($urandom_range(0, 7)) @(negedge clk);
         if ($urandom_range(0, 1) != 0) rd_slot(logic'($urandom_range(0, 1)));
         else                           wr_slot(logic'($urandom_range(0, 1)));
      end

      summary();
      $finish;
   end

endmodule